// File: doc/BRIEF.md
# Dual-Issue In-Order Scoreboard Issue Stage

This block is the issue stage of a two-wide, in-order pipeline. An upstream decoder hands it a pair of decoded instructions. The older one goes in slot 0 and the younger one in slot 1. Each instruction names up to three source registers, each with its own valid bit, one destination register with a write-enable, and a two-bit operation class. Each class has a fixed result latency.

A scoreboard keeps one countdown per architectural register. When a producer issues, its destination countdown is loaded from the producer's class latency. The countdown then drops by one each cycle. A source register counts as ready once its countdown reaches zero.

In each cycle the stage decides to issue nothing, slot 0 alone, or both slots. The younger instruction is held back whenever the older one is. It is also held back when it reads the register the older one writes. A pair is taken from upstream only when both slots will be empty at the end of the cycle. A flush drops the held pair and clears every countdown.

Top module: `dual_issue_sb`

## Requirements
- R1: After reset, both slots are empty, nothing issues, every countdown is zero and `in_ready` is 1.
- R2: `out1_valid` is never 1 in a cycle where `out0_valid` is 0. A stalled slot 0 blocks an otherwise ready slot 1.
- R3: Class encoding: 0 has latency LAT_ALU (1), 1 has LAT_SHF (2), 2 has LAT_MUL (3) and 3 has LAT_LD (4). If a producer issues in cycle t with latency L, a dependent instruction issues no earlier than cycle t+L. It issues in exactly that cycle when nothing else blocks it.
- R4: Any of the three sources can cause a stall. Source i occupies bits [i*RW +: RW] of the source bus and is checked only when bit i of its valid mask is 1.
- R5: Slot 1 does not issue in the same cycle as slot 0 if it reads the slot 0 destination while that destination is enabled.
- R6: When slot 0 issues and slot 1 does not, the slot 1 instruction is in slot 0 on the next cycle. A stalled slot 0 holds its contents.
- R7: While `flush` is 1, nothing issues and `in_ready` is 0. On the next cycle both slots are empty and all countdowns are zero.
- R8: A newer producer of a register replaces that register's pending countdown with its own latency. If both slots of an issuing pair write the same register, the slot 1 latency applies.
- R9: A pair is accepted when `in_valid` and `in_ready` are both 1. `in_ready` is 1 only when both slots will be empty after the current cycle's issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop held pair and clear scoreboard |
| in_valid | input | 1 | Pair offered (slot 0 always valid) |
| in_ready | output | 1 | Pair can be taken this cycle |
| in0_src | input | 3*RW | Older instruction source registers |
| in0_srcv | input | 3 | Older source valid mask |
| in0_dst | input | RW | Older destination register |
| in0_dstv | input | 1 | Older writes a register |
| in0_cls | input | 2 | Older operation class |
| in1_valid | input | 1 | Younger instruction present |
| in1_src | input | 3*RW | Younger source registers |
| in1_srcv | input | 3 | Younger source valid mask |
| in1_dst | input | RW | Younger destination register |
| in1_dstv | input | 1 | Younger writes a register |
| in1_cls | input | 2 | Younger operation class |
| out0_valid | output | 1 | Slot 0 issues this cycle |
| out0_dst | output | RW | Issued slot 0 destination |
| out0_dstv | output | 1 | Issued slot 0 writes a register |
| out0_cls | output | 2 | Issued slot 0 class |
| out1_valid | output | 1 | Slot 1 issues this cycle |
| out1_dst | output | RW | Issued slot 1 destination |
| out1_dstv | output | 1 | Issued slot 1 writes a register |
| out1_cls | output | 2 | Issued slot 1 class |

## Verification
The hardest state to reach is one where the countdowns alone tell the flushed and unflushed outcomes apart. The bench first issues a long-latency load. It then holds a dependent pair stalled behind the load and flushes the pair while the countdown is still high. In the very next cycle it offers a new consumer of the same register. That consumer issues a cycle earlier than it could if the countdown had survived. Ordering of the split pair is reached the same way: a back-to-back dependency inside one pair forces slot 0 to issue alone, and the bench times when the promoted instruction leaves.

// File: rtl/dual_issue_sb.sv
module dual_issue_sb #(
  parameter int NREG    = 32,
  parameter int LAT_ALU = 1,
  parameter int LAT_SHF = 2,
  parameter int LAT_MUL = 3,
  parameter int LAT_LD  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3*$clog2(NREG)-1:0] in0_src,
  input  logic [2:0]        in0_srcv,
  input  logic [$clog2(NREG)-1:0]   in0_dst,
  input  logic              in0_dstv,
  input  logic [1:0]        in0_cls,
  input  logic              in1_valid,
  input  logic [3*$clog2(NREG)-1:0] in1_src,
  input  logic [2:0]        in1_srcv,
  input  logic [$clog2(NREG)-1:0]   in1_dst,
  input  logic              in1_dstv,
  input  logic [1:0]        in1_cls,
  output logic              out0_valid,
  output logic [$clog2(NREG)-1:0]   out0_dst,
  output logic              out0_dstv,
  output logic [1:0]        out0_cls,
  output logic              out1_valid,
  output logic [$clog2(NREG)-1:0]   out1_dst,
  output logic              out1_dstv,
  output logic [1:0]        out1_cls
);
  localparam int RW   = $clog2(NREG);
  localparam int LM01 = (LAT_ALU > LAT_SHF) ? LAT_ALU : LAT_SHF;
  localparam int LM23 = (LAT_MUL > LAT_LD) ? LAT_MUL : LAT_LD;
  localparam int LMAX = (LM01 > LM23) ? LM01 : LM23;
  localparam int CW   = (LMAX <= 2) ? 1 : $clog2(LMAX);

  function automatic logic [CW-1:0] lat_m1(input logic [1:0] c);
    case (c)
      2'd0:    lat_m1 = CW'(LAT_ALU - 1);
      2'd1:    lat_m1 = CW'(LAT_SHF - 1);
      2'd2:    lat_m1 = CW'(LAT_MUL - 1);
      default: lat_m1 = CW'(LAT_LD - 1);
    endcase
  endfunction

  logic            s0_v, s1_v;
  logic [3*RW-1:0] s0_src, s1_src;
  logic [2:0]      s0_srcv, s1_srcv;
  logic [RW-1:0]   s0_dst, s1_dst;
  logic            s0_dstv, s1_dstv;
  logic [1:0]      s0_cls, s1_cls;

  logic [CW-1:0]   cnt [NREG];
  logic [2:0]      haz0, haz1, dep1;
  logic            go0, go1, accept;
  logic [NREG-1:0] ld0, ld1;

  for (genvar i = 0; i < 3; i++) begin : g_src
    assign haz0[i] = s0_srcv[i] && (cnt[s0_src[i*RW +: RW]] != '0);
    assign haz1[i] = s1_srcv[i] && (cnt[s1_src[i*RW +: RW]] != '0);
    assign dep1[i] = s1_srcv[i] && s0_dstv && (s1_src[i*RW +: RW] == s0_dst);
  end

  assign go0      = s0_v && !flush && (haz0 == 3'b000);
  assign go1      = go0 && s1_v && (haz1 == 3'b000) && (dep1 == 3'b000);
  assign in_ready = !flush && (!s0_v || (go0 && (go1 || !s1_v)));
  assign accept   = in_valid && in_ready;

  for (genvar r = 0; r < NREG; r++) begin : g_sb
    assign ld0[r] = go0 && s0_dstv && (s0_dst == RW'(r));
    assign ld1[r] = go1 && s1_dstv && (s1_dst == RW'(r));

    always_ff @(posedge clk) begin
      if (!rst_n || flush) cnt[r] <= '0;
      else if (ld1[r])     cnt[r] <= lat_m1(s1_cls);
      else if (ld0[r])     cnt[r] <= lat_m1(s0_cls);
      else if (cnt[r] != '0) cnt[r] <= cnt[r] - 1'b1;
    end

    p_countdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !ld0[r] && !ld1[r] && cnt[r] != '0) |=> (cnt[r] == $past(cnt[r]) - 1'b1));
    p_flush_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt[r] == '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      s0_v <= 1'b0;
      s1_v <= 1'b0;
    end else if (accept) begin
      s0_v <= 1'b1;      s0_src <= in0_src; s0_srcv <= in0_srcv;
      s0_dst <= in0_dst; s0_dstv <= in0_dstv; s0_cls <= in0_cls;
      s1_v <= in1_valid; s1_src <= in1_src; s1_srcv <= in1_srcv;
      s1_dst <= in1_dst; s1_dstv <= in1_dstv; s1_cls <= in1_cls;
    end else if (go0 && !go1 && s1_v) begin
      s0_v <= 1'b1;      s0_src <= s1_src;  s0_srcv <= s1_srcv;
      s0_dst <= s1_dst;  s0_dstv <= s1_dstv; s0_cls <= s1_cls;
      s1_v <= 1'b0;
    end else if (go0) begin
      s0_v <= 1'b0;
      s1_v <= 1'b0;
    end
  end

  assign out0_valid = go0;
  assign out0_dst   = s0_dst;
  assign out0_dstv  = s0_dstv;
  assign out0_cls   = s0_cls;
  assign out1_valid = go1;
  assign out1_dst   = s1_dst;
  assign out1_dstv  = s1_dstv;
  assign out1_cls   = s1_cls;

  p_young_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out1_valid |-> out0_valid);
  p_promote_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out0_valid && !out1_valid && s1_v) |=> (s0_v && !s1_v && s0_dst == $past(s1_dst)));
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_v && !out0_valid && !flush) |=> (s0_v && s0_dst == $past(s0_dst) && s0_cls == $past(s0_cls)));
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!s0_v && !s1_v && !out0_valid));
endmodule

// File: tb/dual_issue_sb_tb.sv
module dual_issue_sb_tb_top;
  localparam int NREG = 32;
  localparam int RW = $clog2(NREG);

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, in_valid = 1'b0, in_ready;
  logic [3*RW-1:0] in0_src = '0, in1_src = '0;
  logic [2:0] in0_srcv = '0, in1_srcv = '0;
  logic [RW-1:0] in0_dst = '0, in1_dst = '0;
  logic in0_dstv = 1'b0, in1_dstv = 1'b0, in1_valid = 1'b0;
  logic [1:0] in0_cls = '0, in1_cls = '0;
  logic out0_valid, out0_dstv, out1_valid, out1_dstv;
  logic [RW-1:0] out0_dst, out1_dst;
  logic [1:0] out0_cls, out1_cls;

  always #5 clk = ~clk;

  dual_issue_sb #(.NREG(NREG)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in0_src(in0_src), .in0_srcv(in0_srcv), .in0_dst(in0_dst), .in0_dstv(in0_dstv), .in0_cls(in0_cls),
    .in1_valid(in1_valid), .in1_src(in1_src), .in1_srcv(in1_srcv), .in1_dst(in1_dst),
    .in1_dstv(in1_dstv), .in1_cls(in1_cls),
    .out0_valid(out0_valid), .out0_dst(out0_dst), .out0_dstv(out0_dstv), .out0_cls(out0_cls),
    .out1_valid(out1_valid), .out1_dst(out1_dst), .out1_dstv(out1_dstv), .out1_cls(out1_cls));

  typedef struct { logic [2:0] sv; int a; int b; int c; int d; int cls; } ins_t;
  typedef struct { int cyc; int slot; int dst; string req; } exp_t;

  exp_t q[$];
  int cyc = 0, checks = 0, fails = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic ins_t mk(int d, int cls, logic [2:0] sv = 3'b000, int a = 0, int b = 0, int c = 0);
    ins_t x;
    x.sv = sv; x.a = a; x.b = b; x.c = c; x.d = d; x.cls = cls;
    return x;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expq(int c, int slot, int dst, string req);
    exp_t e;
    e.cyc = c; e.slot = slot; e.dst = dst; e.req = req;
    q.push_back(e);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic present(ins_t x, logic v1 = 1'b0, ins_t y = '{3'b000, 0, 0, 0, 0, 0});
    in_valid = 1'b1;
    in0_src = {RW'(x.c), RW'(x.b), RW'(x.a)}; in0_srcv = x.sv;
    in0_dst = RW'(x.d); in0_dstv = 1'b1; in0_cls = 2'(x.cls);
    in1_valid = v1;
    in1_src = {RW'(y.c), RW'(y.b), RW'(y.a)}; in1_srcv = y.sv;
    in1_dst = RW'(y.d); in1_dstv = 1'b1; in1_cls = 2'(y.cls);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    in1_valid = 1'b0;
  endtask

  task automatic settle();
    idle();
    repeat (8) tick();
  endtask

  task automatic pop_cmp(int slot, int dst);
    exp_t e;
    if (q.size() == 0) begin
      check("R2 unexpected issue slot", slot, -1);
      return;
    end
    e = q.pop_front();
    check({e.req, " issue cycle"}, cyc, e.cyc);
    check({e.req, " issue slot"}, slot, e.slot);
    check({e.req, " issue dst"}, dst, e.dst);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      while (q.size() > 0 && q[0].cyc < cyc) begin
        check({q[0].req, " missing issue at cycle"}, cyc, q[0].cyc);
        void'(q.pop_front());
      end
      if (out0_valid) pop_cmp(0, int'(out0_dst));
      if (out1_valid) pop_cmp(1, int'(out1_dst));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_ready", int'(in_ready), 1);
    check("R1 out0_valid", int'(out0_valid), 0);
    check("R1 out1_valid", int'(out1_valid), 0);
    tick();

    // independent pair: both issue together; R9 ready while both drain
    c = cyc;
    present(mk(1, 0), 1'b1, mk(2, 0, 3'b011, 3, 4));
    expq(c + 1, 0, 1, "R2"); expq(c + 1, 1, 2, "R2");
    tick(); idle();
    @(negedge clk); check("R9 ready when pair drains", int'(in_ready), 1);
    settle();

    // R5 intra-pair dependency, R6 promotion, R3 mul latency
    c = cyc;
    present(mk(5, 2), 1'b1, mk(6, 0, 3'b001, 5));
    expq(c + 1, 0, 5, "R5"); expq(c + 4, 0, 6, "R3");
    tick(); idle();
    @(negedge clk); check("R9 ready low while slot1 stays", int'(in_ready), 0);
    tick();
    @(negedge clk); check("R6 promoted slot holds, ready low", int'(in_ready), 0);
    settle();

    // R2 gating: slot0 waits on load through source 2 (R4), independent slot1 waits too
    c = cyc;
    present(mk(7, 3));
    expq(c + 1, 0, 7, "R3");
    tick();
    present(mk(8, 0, 3'b100, 0, 0, 7), 1'b1, mk(9, 0));
    expq(c + 5, 0, 8, "R4"); expq(c + 5, 1, 9, "R2");
    tick(); idle();
    settle();

    // R4 masked source is ignored
    c = cyc;
    present(mk(10, 3));
    expq(c + 1, 0, 10, "R3");
    tick();
    present(mk(12, 0, 3'b001, 11, 10));
    expq(c + 2, 0, 12, "R4");
    tick(); idle();
    settle();

    // R3 single-cycle latency allows back-to-back
    c = cyc;
    present(mk(13, 0));
    expq(c + 1, 0, 13, "R3");
    tick();
    present(mk(14, 0, 3'b001, 13));
    expq(c + 2, 0, 14, "R3");
    tick(); idle();
    settle();

    // R3 shift latency through source 1
    c = cyc;
    present(mk(15, 1));
    expq(c + 1, 0, 15, "R3");
    tick();
    present(mk(22, 0, 3'b010, 0, 15));
    expq(c + 3, 0, 22, "R3");
    tick(); idle();
    settle();

    // R8 same destination in both slots: younger latency wins
    c = cyc;
    present(mk(16, 3), 1'b1, mk(16, 0));
    expq(c + 1, 0, 16, "R8"); expq(c + 1, 1, 16, "R8");
    tick();
    present(mk(17, 0, 3'b001, 16));
    expq(c + 2, 0, 17, "R8");
    tick(); idle();
    settle();

    // R7 flush drops stalled pair and clears pending countdown
    c = cyc;
    present(mk(18, 3));
    expq(c + 1, 0, 18, "R3");
    tick();
    present(mk(19, 0, 3'b001, 18), 1'b1, mk(20, 0));
    tick(); idle();
    flush = 1'b1;
    @(negedge clk);
    check("R7 ready low during flush", int'(in_ready), 0);
    check("R7 no issue during flush", int'(out0_valid), 0);
    tick();
    flush = 1'b0;
    present(mk(21, 0, 3'b001, 18));
    expq(c + 4, 0, 21, "R7");
    tick(); idle();
    settle();

    check("R3 all expected issues seen", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule